// File: doc/BRIEF.md
# Alarm and Kickstart Power-On Sequencer

This block lives in the always-on battery domain and brings a sleeping system back up. It has two wake sources. The first is a calendar alarm, where the present date, hour, minute and second all equal the programmed alarm values. The second is a kickstart button, where the KS pin is pulled low and held long enough to pass a minimum-width qualifier. Either source, when armed, enables an open-drain pull-down on the power-enable line and records which source fired in a status flag.

After a trigger the block waits a bounded number of cycles for the main supply to report good. If the supply arrives, the block keeps power on, pulls the interrupt line low and clears a software-owned power-hold bit. Power then stays on for as long as that bit reads 0. If the supply does not arrive in time, the block releases the power line, leaves the interrupt line undriven and keeps the flag. Software can then see the failed attempt at a later power-up.

Once the system is powered, both sources keep setting their flags. Each flag drives the interrupt only when its enable is set. An external pending-interrupt input is also ORed into the interrupt line. Software writes a 5-bit control word through a one-cycle write strobe.

Top module: `pwr_wake_seq`

## Requirements
- R1: After reset the power and interrupt pull-downs are off and `reg_q` reads 5'b10000. Its bit layout is [0] wake enable, [1] kickstart enable, [2] wake flag, [3] kickstart flag, [4] power-hold.
- R2: While powered down with the wake enable set, a new full match of date, hour, minute and second against the alarm fields pulls `pwr_pull` high on the next clock edge and sets the wake flag. A mismatch in any single field, or a cleared wake enable, leaves `pwr_pull` low.
- R3: While powered down with the kickstart enable set, `ks_n` held low for at least KS_MIN_CYC synchronized cycles pulls `pwr_pull` high and sets the kickstart flag. A shorter low pulse, or a cleared kickstart enable, does nothing.
- R4: If `vcc_good` stays low for TIMEOUT_CYC cycles after a trigger, `pwr_pull` drops, `irq_pull` stays low and the triggering flag remains set.
- R5: If `vcc_good` rises within the window, `pwr_pull` stays high, the power-hold bit becomes 0 and `irq_pull` goes high.
- R6: While powered, `pwr_pull` is high exactly while the power-hold bit is 0. Writing 1 to it releases power. When `vcc_good` falls afterwards, the block returns to powered-down monitoring.
- R7: A write sets both enables and the hold bit from bits [0], [1] and [4]. Writing 0 to flag bits [2] or [3] clears that flag. Writing 1 to a flag bit leaves it unchanged.
- R8: While powered, `irq_pull` equals (wake flag AND wake enable) OR (kickstart flag AND kickstart enable) OR `ext_irq`. It is never high while powered down or while waiting for supply.
- R9: While powered, an alarm match or a qualified KS pulse sets its flag even when that source's enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_date | input | FIELD_W | Current day of month |
| cur_hour | input | FIELD_W | Current hour |
| cur_min | input | FIELD_W | Current minute |
| cur_sec | input | FIELD_W | Current second |
| alm_date | input | FIELD_W | Alarm day of month |
| alm_hour | input | FIELD_W | Alarm hour |
| alm_min | input | FIELD_W | Alarm minute |
| alm_sec | input | FIELD_W | Alarm second |
| ks_n | input | 1 | Kickstart pin, asynchronous, active low |
| vcc_good | input | 1 | Main supply above its fail threshold |
| ext_irq | input | 1 | Other pending interrupt sources |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 5 | Control word (layout as in R1) |
| reg_q | output | 5 | Control and status read-back |
| pwr_pull | output | 1 | 1 = pull the power-enable line low |
| irq_pull | output | 1 | 1 = pull the interrupt line low |

## Verification
The alarm comparator is tried with a table of time and alarm pairs. The table holds a full match, a mismatch in exactly one field for each of the four fields, and matches at the lowest and highest field values. One entry is an exact match with the source disarmed, which separates the enable gating from the comparison itself. The kickstart path is driven with a pulse shorter than the qualifier and with one well past it, both armed and disarmed, so that width filtering is told apart from enable gating. Two supply-return patterns are used: a supply that never comes, to expose the timeout and flag retention, and a supply that comes at once, to expose the hold-bit clearing and the interrupt composition from flags, enables and the external input.

// File: rtl/pwr_wake_pkg.sv
`timescale 1ns/1ps
// pwr_wake_pkg: shared types and control-word bit positions for the
// power-on sequencer. Assumes a 5-bit control word.
package pwr_wake_pkg;
    typedef enum logic [1:0] {
        SEQ_OFF     = 2'd0,
        SEQ_WAIT    = 2'd1,
        SEQ_ON      = 2'd2,
        SEQ_RELEASE = 2'd3
    } seq_state_e;

    localparam int CTRL_W   = 5;
    localparam int B_WEN    = 0;
    localparam int B_KEN    = 1;
    localparam int B_WFLAG  = 2;
    localparam int B_KFLAG  = 3;
    localparam int B_HOLD   = 4;
endpackage

// File: rtl/alarm_cmp.sv
`timescale 1ns/1ps
// alarm_cmp: compares each time field against its alarm field and emits a
// one-cycle pulse when the full match first becomes true.
// Assumes fields are stable between clock edges (same clock domain).
module alarm_cmp #(
    parameter int FIELD_W    = 8,
    parameter int NUM_FIELDS = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]   now_f,
    input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]   alm_f,
    output logic                                 match_rise
);
    logic [NUM_FIELDS-1:0] field_eq;
    logic                  match_all;
    logic                  match_q;

    // One equality comparator per field.
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        assign field_eq[i] = (now_f[i] == alm_f[i]);
    end

    assign match_all = &field_eq;

    // Remember last cycle's match so a held match fires once.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match_all;
    end

    assign match_rise = match_all & ~match_q;

    a_r2_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        match_rise |=> !match_rise);
endmodule

// File: rtl/ks_qualifier.sv
`timescale 1ns/1ps
// ks_qualifier: synchronizes the asynchronous kickstart pin and emits one
// pulse once it has been low for KS_MIN_CYC consecutive synchronized cycles.
// Assumes KS_MIN_CYC >= 1.
module ks_qualifier #(
    parameter int KS_MIN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ks_n,
    output logic ks_evt
);
    localparam int CW = $clog2(KS_MIN_CYC + 1);

    logic          sync1, sync2;
    logic [CW-1:0] low_cnt;

    // Two-flop synchronizer, idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= ks_n;
            sync2 <= sync1;
        end
    end

    // Count low cycles, saturating one past the qualify point.
    always_ff @(posedge clk) begin
        if (!rst_n)                          low_cnt <= '0;
        else if (sync2)                      low_cnt <= '0;
        else if (low_cnt != CW'(KS_MIN_CYC)) low_cnt <= low_cnt + 1'b1;
    end

    assign ks_evt = !sync2 && (low_cnt == CW'(KS_MIN_CYC - 1));

    a_r3_one_event_per_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ks_evt |=> !ks_evt);
    a_r3_event_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        ks_evt |-> !sync2);
endmodule

// File: rtl/pwr_seq_core.sv
`timescale 1ns/1ps
// pwr_seq_core: power-on state machine plus the control/status word.
// Takes trigger pulses from the alarm and kickstart paths, times the
// supply-return window and drives the two open-drain pull enables.
// Assumes TIMEOUT_CYC >= 2 and vcc_good already synchronized.
module pwr_seq_core
    import pwr_wake_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              match_rise,
    input  logic              ks_evt,
    input  logic              vcc_good,
    input  logic              ext_irq,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] reg_q,
    output logic              pwr_pull,
    output logic              irq_pull
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    seq_state_e state_q;
    logic [TW-1:0] timer_q;
    logic wen_q, ken_q, wflag_q, kflag_q, hold_q;
    logic down, powered, wake_trig, ks_trig, set_w, set_k, win_ok, win_end;

    // Decode state groups and trigger conditions.
    always_comb begin
        down      = (state_q == SEQ_OFF);
        powered   = (state_q == SEQ_ON) || (state_q == SEQ_RELEASE);
        wake_trig = down && wen_q && match_rise;
        ks_trig   = down && ken_q && ks_evt;
        set_w     = down ? wake_trig : match_rise;
        set_k     = down ? ks_trig   : ks_evt;
        win_ok    = (state_q == SEQ_WAIT) && vcc_good;
        win_end   = (state_q == SEQ_WAIT) && !vcc_good
                    && (timer_q == TW'(TIMEOUT_CYC - 1));
    end

    // Sequencer state and supply-window timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_OFF;
            timer_q <= '0;
        end else begin
            case (state_q)
                SEQ_OFF: begin
                    timer_q <= '0;
                    if (wake_trig || ks_trig) state_q <= SEQ_WAIT;
                end
                SEQ_WAIT: begin
                    if (win_ok)       state_q <= SEQ_ON;
                    else if (win_end) state_q <= SEQ_OFF;
                    else              timer_q <= timer_q + 1'b1;
                end
                SEQ_ON: begin
                    if (hold_q) state_q <= SEQ_RELEASE;
                end
                default: begin
                    if (!vcc_good)   state_q <= SEQ_OFF;
                    else if (!hold_q) state_q <= SEQ_ON;
                end
            endcase
        end
    end

    // Enable bits follow the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q <= 1'b0;
            ken_q <= 1'b0;
        end else if (wr_en) begin
            wen_q <= wr_data[B_WEN];
            ken_q <= wr_data[B_KEN];
        end
    end

    // Flags: an event sets, a written 0 clears, event wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wflag_q <= 1'b0;
            kflag_q <= 1'b0;
        end else begin
            if (set_w)                           wflag_q <= 1'b1;
            else if (wr_en && !wr_data[B_WFLAG]) wflag_q <= 1'b0;
            if (set_k)                           kflag_q <= 1'b1;
            else if (wr_en && !wr_data[B_KFLAG]) kflag_q <= 1'b0;
        end
    end

    // Hold bit: cleared on a successful power-on, else software-written.
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_q <= 1'b1;
        else if (win_ok) hold_q <= 1'b0;
        else if (wr_en)  hold_q <= wr_data[B_HOLD];
    end

    assign reg_q    = {hold_q, kflag_q, wflag_q, ken_q, wen_q};
    assign pwr_pull = (state_q == SEQ_WAIT) || (powered && !hold_q);
    assign irq_pull = powered && ((wflag_q && wen_q) || (kflag_q && ken_q) || ext_irq);

    a_r2_wake_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (down && wen_q && match_rise) |=> (state_q == SEQ_WAIT && wflag_q));
    a_r3_ks_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (down && ken_q && ks_evt) |=> (state_q == SEQ_WAIT && kflag_q));
    a_r4_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && !wr_en) |=> (down && (wflag_q || kflag_q) && !pwr_pull));
    a_r5_power_on: assert property (@(posedge clk) disable iff (!rst_n)
        win_ok |=> (state_q == SEQ_ON && !hold_q && pwr_pull));
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_ON && hold_q) |=> (state_q == SEQ_RELEASE));
    a_r7_write_one_keeps_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_WFLAG] && !wflag_q && !set_w) |=> !wflag_q);
    a_r8_quiet_when_down: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pull) |-> powered);
endmodule

// File: rtl/pwr_wake_seq.sv
`timescale 1ns/1ps
// pwr_wake_seq: top of the battery-domain power-on sequencer. Packs the
// time and alarm fields, qualifies the kickstart pin and drives the
// sequencer core. Assumes all inputs except ks_n are synchronous to clk.
module pwr_wake_seq
    import pwr_wake_pkg::*;
#(
    parameter int FIELD_W     = 8,
    parameter int TIMEOUT_CYC = 1024,
    parameter int KS_MIN_CYC  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] cur_date,
    input  logic [FIELD_W-1:0] cur_hour,
    input  logic [FIELD_W-1:0] cur_min,
    input  logic [FIELD_W-1:0] cur_sec,
    input  logic [FIELD_W-1:0] alm_date,
    input  logic [FIELD_W-1:0] alm_hour,
    input  logic [FIELD_W-1:0] alm_min,
    input  logic [FIELD_W-1:0] alm_sec,
    input  logic               ks_n,
    input  logic               vcc_good,
    input  logic               ext_irq,
    input  logic               wr_en,
    input  logic [4:0]         wr_data,
    output logic [4:0]         reg_q,
    output logic               pwr_pull,
    output logic               irq_pull
);
    localparam int NF = 4;

    logic [NF-1:0][FIELD_W-1:0] now_f, alm_f;
    logic match_rise, ks_evt;

    assign now_f = {cur_date, cur_hour, cur_min, cur_sec};
    assign alm_f = {alm_date, alm_hour, alm_min, alm_sec};

    alarm_cmp #(.FIELD_W(FIELD_W), .NUM_FIELDS(NF)) u_cmp (
        .clk(clk), .rst_n(rst_n), .now_f(now_f), .alm_f(alm_f),
        .match_rise(match_rise)
    );

    ks_qualifier #(.KS_MIN_CYC(KS_MIN_CYC)) u_ks (
        .clk(clk), .rst_n(rst_n), .ks_n(ks_n), .ks_evt(ks_evt)
    );

    pwr_seq_core #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_core (
        .clk(clk), .rst_n(rst_n), .match_rise(match_rise), .ks_evt(ks_evt),
        .vcc_good(vcc_good), .ext_irq(ext_irq), .wr_en(wr_en),
        .wr_data(wr_data), .reg_q(reg_q), .pwr_pull(pwr_pull),
        .irq_pull(irq_pull)
    );
endmodule

// File: tb/pwr_wake_seq_test.sv
`timescale 1ns/1ps
module pwr_wake_seq_test;
    localparam int TO  = 20;
    localparam int KSM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] cur_date = 0, cur_hour = 0, cur_min = 0, cur_sec = 0;
    logic [7:0] alm_date = 0, alm_hour = 0, alm_min = 0, alm_sec = 0;
    logic ks_n = 1'b1, vcc_good = 1'b0, ext_irq = 1'b0, wr_en = 1'b0;
    logic [4:0] wr_data = '0;
    logic [4:0] reg_q;
    logic pwr_pull, irq_pull;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    pwr_wake_seq #(.FIELD_W(8), .TIMEOUT_CYC(TO), .KS_MIN_CYC(KSM)) uut (
        .clk(clk), .rst_n(rst_n),
        .cur_date(cur_date), .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
        .alm_date(alm_date), .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec),
        .ks_n(ks_n), .vcc_good(vcc_good), .ext_irq(ext_irq), .wr_en(wr_en),
        .wr_data(wr_data), .reg_q(reg_q), .pwr_pull(pwr_pull), .irq_pull(irq_pull)
    );

    // {enable, expect, cur{date,hour,min,sec}, alm{date,hour,min,sec}}
    localparam logic [65:0] VEC [8] = '{
        {1'b1, 1'b1, 32'h15083045, 32'h15083045},
        {1'b1, 1'b0, 32'h15083046, 32'h15083045},
        {1'b1, 1'b0, 32'h15083145, 32'h15083045},
        {1'b1, 1'b0, 32'h15093045, 32'h15083045},
        {1'b1, 1'b0, 32'h16083045, 32'h15083045},
        {1'b0, 1'b0, 32'h15083045, 32'h15083045},
        {1'b1, 1'b1, 32'h01000000, 32'h01000000},
        {1'b1, 1'b1, 32'h1F173B3B, 32'h1F173B3B}
    };

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; vcc_good = 1'b0; ext_irq = 1'b0; ks_n = 1'b1; wr_en = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [4:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic set_time(logic [31:0] t);
        {cur_date, cur_hour, cur_min, cur_sec} = t;
    endtask

    // Make a fresh alarm match: one mismatching cycle, then equal fields.
    task automatic fire_alarm();
        set_time({alm_date, alm_hour, alm_min, alm_sec ^ 8'h01});
        tick();
        set_time({alm_date, alm_hour, alm_min, alm_sec});
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick();
        do_reset();
        // R1 reset state
        chk("R1 pwr", pwr_pull, 0);
        chk("R1 irq", irq_pull, 0);
        chk("R1 reg", reg_q, 8'h10);

        // R2 alarm comparator table
        for (int v = 0; v < 8; v++) begin
            do_reset();
            {alm_date, alm_hour, alm_min, alm_sec} = VEC[v][31:0];
            set_time(VEC[v][63:32] ^ 32'h1);
            wr({4'b1000, VEC[v][65]});
            set_time(VEC[v][63:32]);
            tick();
            chk($sformatf("R2 vec%0d pwr", v), pwr_pull, VEC[v][64]);
            chk($sformatf("R2 vec%0d flag", v), reg_q[2], VEC[v][64]);
        end

        // R4 timeout with no supply
        do_reset();
        {alm_date, alm_hour, alm_min, alm_sec} = 32'h15083045;
        wr(5'b10001);
        fire_alarm();
        chk("R2 trigger", pwr_pull, 1);
        tick(TO - 1);
        chk("R4 still waiting", pwr_pull, 1);
        tick();
        chk("R4 released", pwr_pull, 0);
        chk("R4 irq quiet", irq_pull, 0);
        chk("R4 flag kept", reg_q[2], 1);

        // R5 supply returns in window
        wr(5'b10001);
        fire_alarm();
        vcc_good = 1'b1;
        tick();
        chk("R5 pwr held", pwr_pull, 1);
        chk("R5 irq", irq_pull, 1);
        chk("R5 hold cleared", reg_q[4], 0);

        // R7/R8 clear flags, irq drops
        wr(5'b00001);
        chk("R8 irq after clear", irq_pull, 0);
        chk("R7 wake flag cleared", reg_q[2], 0);

        // R9 powered match with enable off sets flag but no irq
        wr(5'b00000);
        fire_alarm();
        chk("R9 flag set while disabled", reg_q[2], 1);
        chk("R9 irq gated", irq_pull, 0);
        wr(5'b00101);
        chk("R8 flag and enable", irq_pull, 1);

        // R8 external source
        wr(5'b00001);
        ext_irq = 1'b1;
        #1;
        chk("R8 ext irq", irq_pull, 1);
        ext_irq = 1'b0;
        #1;
        chk("R8 ext released", irq_pull, 0);

        // R7 writing 1 to clear flags does not set them
        wr(5'b01101);
        chk("R7 write one no set", reg_q[3:2], 0);

        // R6 hold release and return to monitoring
        wr(5'b10001);
        chk("R6 pwr released", pwr_pull, 0);
        tick();
        vcc_good = 1'b0;
        tick();
        chk("R6 irq after drop", irq_pull, 0);
        fire_alarm();
        chk("R6 monitoring again", pwr_pull, 1);
        tick(TO + 2);
        chk("R4 second timeout", pwr_pull, 0);

        // R3 kickstart: short pulse ignored, long pulse triggers
        wr(5'b10010);
        ks_n = 1'b0; tick(KSM - 1); ks_n = 1'b1;
        tick(8);
        chk("R3 short pulse", pwr_pull, 0);
        ks_n = 1'b0; tick(10); ks_n = 1'b1;
        chk("R3 long pulse pwr", pwr_pull, 1);
        chk("R3 ks flag", reg_q[3], 1);
        tick(TO + 2);
        chk("R4 ks flag kept", reg_q[3], 1);

        // R3 disarmed kickstart
        wr(5'b10000);
        ks_n = 1'b0; tick(10); ks_n = 1'b1;
        tick(2);
        chk("R3 disarmed pwr", pwr_pull, 0);
        chk("R3 disarmed flag", reg_q[3], 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule